// File: doc/BRIEF.md
# Transfer Completion Interrupt and Chain Router

This block sits beside a DMA request sequencer and turns completion reports into state that software and other channels can see. Each report carries a control word and a flag that says whether it belongs to the last request of a parameter set. A 6-bit completion code in the control word picks one of 64 bit positions. Four enable bits in the same word decide whether that bit is set in the interrupt-pending register, in the chained-event register, in both, or in neither. The choice depends on whether the report is intermediate or final.

Reports arrive on two ports. One port fires when a request is handed to the transfer engine. The other fires when the engine acknowledges that the data has moved. A mode bit in the control word picks which of the two counts as completion, so an early-mode channel can signal while its data is still in flight. The pending register is masked by a software-owned interrupt-enable register, and the masked bits are ORed into one level-sensitive CPU interrupt line. Software clears pending and chained bits with write-one-to-clear ports, and sets or clears enable bits through separate ports.

Top module: `cmpl_event_router`

## Requirements
- R1: After reset, the pending, chained-event and interrupt-enable registers are all zero and `irq_o` is low.
- R2: The completion code sits at control bits 17:12 and selects the bit position. With the final-interrupt enable (bit 20) set, a report with `last` high sets the pending bit at that code. A report with `last` low does not set it through this enable.
- R3: With the intermediate-interrupt enable (bit 21) set, a report with `last` low sets the pending bit at the code. A report with `last` high does not set it through this enable.
- R4: The final-chain enable (bit 22) and the intermediate-chain enable (bit 23) follow the same final-only and all-but-final rule, but they set the chained-event bit at the code.
- R5: Control bit 11 selects the completion point. At 0, only reports on the data-done port count. At 1, only reports on the handoff port count. A report on the other port changes nothing.
- R6: A counted report is visible on `pend_o` / `chain_o` one clock after the report is presented, and not before.
- R7: A 1 on a bit of `pend_clr_i` or `chain_clr_i` clears that bit at the next clock edge. Bits written with 0 keep their value.
- R8: If a report sets a pending or chained bit in the same cycle that software clears it, the bit ends up set.
- R9: `ien_set_i` sets and `ien_clr_i` clears interrupt-enable bits. When both hit the same bit in the same cycle, the bit ends up set.
- R10: `irq_o` is a level equal to the OR over all bits of pending AND enable. A pending bit with its enable at 0 does not raise it.
- R11: Reports on both ports in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hand_vld_i | input | 1 | Report at the request handoff point |
| hand_last_i | input | 1 | Handoff report belongs to the final request |
| hand_ctrl_i | input | 32 | Control word of the handoff report |
| done_vld_i | input | 1 | Report at the data-done acknowledge point |
| done_last_i | input | 1 | Data-done report belongs to the final request |
| done_ctrl_i | input | 32 | Control word of the data-done report |
| pend_clr_i | input | 64 | Write-one-to-clear for pending bits |
| chain_clr_i | input | 64 | Write-one-to-clear for chained-event bits |
| ien_set_i | input | 64 | Write-one-to-set for interrupt-enable bits |
| ien_clr_i | input | 64 | Write-one-to-clear for interrupt-enable bits |
| pend_o | output | 64 | Interrupt-pending register |
| chain_o | output | 64 | Chained-event register |
| ien_o | output | 64 | Interrupt-enable register |
| irq_o | output | 1 | CPU interrupt level |

## Verification
A hardware set from a completion report and a software clear of the same bit can land in one cycle. So can a set and a clear of the same enable bit. The bench provokes each case by driving the report and the clear on the same bit in one cycle. It judges the result by the bit reading 1 after the next edge, and it checks that neighbouring bits are untouched. It also drives both report ports in one cycle with different codes and expects both bits to be set.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
   // Control word field positions (the sequencer encodes them this way)
   localparam int MODE_BIT    = 11;
   localparam int CODE_LSB    = 12;
   localparam int FIN_INT_BIT = 20;
   localparam int MID_INT_BIT = 21;
   localparam int FIN_CHN_BIT = 22;
   localparam int MID_CHN_BIT = 23;
   localparam int CTRL_MIN_W  = 24;

   // Completion point selected by the mode bit
   typedef enum logic {
      PT_DATA_DONE = 1'b0,
      PT_HANDOFF   = 1'b1
   } cmpl_point_e;

   typedef struct packed {
      logic fin_int;
      logic mid_int;
      logic fin_chn;
      logic mid_chn;
   } cmpl_en_t;
endpackage

// File: rtl/cmpl_decode.sv
module cmpl_decode
   import cmpl_pkg::*;
#(
   parameter int          CODE_W = 6,
   parameter int          CTRL_W = 32,
   parameter cmpl_point_e POINT  = PT_DATA_DONE,
   localparam int         NUM    = 1 << CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic              last_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic [NUM-1:0]    int_set_o,
   output logic [NUM-1:0]    chn_set_o
);
   if (CTRL_W < CTRL_MIN_W) begin : g_bad_ctrl_w
      $error("cmpl_decode: CTRL_W too small for the enable fields");
   end
   if (CODE_LSB + CODE_W > FIN_INT_BIT) begin : g_bad_code_w
      $error("cmpl_decode: CODE_W overlaps the enable fields");
   end

   logic [CODE_W-1:0] code;
   cmpl_en_t          en;
   logic              counts;
   logic              int_hit;
   logic              chn_hit;
   logic [NUM-1:0]    code_dec;
   logic              unused_ctrl_bits;

   assign code   = ctrl_i[CODE_LSB +: CODE_W];
   assign en     = '{fin_int: ctrl_i[FIN_INT_BIT], mid_int: ctrl_i[MID_INT_BIT],
                     fin_chn: ctrl_i[FIN_CHN_BIT], mid_chn: ctrl_i[MID_CHN_BIT]};
   assign counts = vld_i && (cmpl_point_e'(ctrl_i[MODE_BIT]) == POINT);

   assign int_hit = counts && (last_i ? en.fin_int : en.mid_int);
   assign chn_hit = counts && (last_i ? en.fin_chn : en.mid_chn);

   for (genvar i = 0; i < NUM; i++) begin : g_dec
      assign code_dec[i] = (code == CODE_W'(i));
   end

   assign int_set_o = int_hit ? code_dec : '0;
   assign chn_set_o = chn_hit ? code_dec : '0;

   assign unused_ctrl_bits = ^ctrl_i;

   // R2
   int_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(int_set_o));
   // R4
   chn_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chn_set_o));
   // R5
   wrong_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_i[MODE_BIT] != logic'(POINT)) |-> (int_set_o == '0 && chn_set_o == '0));
endmodule

// File: rtl/cmpl_bitreg.sv
module cmpl_bitreg #(
   parameter int W        = 64,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("cmpl_bitreg: W must be positive");
   end

   logic [W-1:0] q_d;

   if (SET_WINS) begin : g_set_wins
      assign q_d = (q_o & ~clr_i) | set_i;
      // R8
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
   end else begin : g_clr_wins
      assign q_d = (q_o | set_i) & ~clr_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= q_d;
   end

   // R7
   clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/cmpl_irq_reduce.sv
module cmpl_irq_reduce #(
   parameter int W    = 64,
   parameter int LEAF = 8,
   localparam int NGRP = W / LEAF
) (
   input  logic [W-1:0] pend_i,
   input  logic [W-1:0] ien_i,
   output logic         irq_o
);
   if (W % LEAF != 0) begin : g_bad_leaf
      $error("cmpl_irq_reduce: W must be a multiple of LEAF");
   end

   logic [NGRP-1:0] grp_hit;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_hit[g] = |(pend_i[g*LEAF +: LEAF] & ien_i[g*LEAF +: LEAF]);
   end

   assign irq_o = |grp_hit;
endmodule

// File: rtl/cmpl_event_router.sv
module cmpl_event_router
   import cmpl_pkg::*;
#(
   parameter int  CODE_W = 6,
   parameter int  CTRL_W = 32,
   parameter int  LEAF   = 8,
   localparam int NUM    = 1 << CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hand_vld_i,
   input  logic              hand_last_i,
   input  logic [CTRL_W-1:0] hand_ctrl_i,
   input  logic              done_vld_i,
   input  logic              done_last_i,
   input  logic [CTRL_W-1:0] done_ctrl_i,
   input  logic [NUM-1:0]    pend_clr_i,
   input  logic [NUM-1:0]    chain_clr_i,
   input  logic [NUM-1:0]    ien_set_i,
   input  logic [NUM-1:0]    ien_clr_i,
   output logic [NUM-1:0]    pend_o,
   output logic [NUM-1:0]    chain_o,
   output logic [NUM-1:0]    ien_o,
   output logic              irq_o
);
   localparam int NPORT = 2;

   logic              p_vld  [NPORT];
   logic              p_last [NPORT];
   logic [CTRL_W-1:0] p_ctrl [NPORT];
   logic [NUM-1:0]    p_int  [NPORT];
   logic [NUM-1:0]    p_chn  [NPORT];
   logic [NUM-1:0]    pend_set;
   logic [NUM-1:0]    chain_set;

   // port 0: handoff point, port 1: data-done point
   assign p_vld[0]  = hand_vld_i;
   assign p_last[0] = hand_last_i;
   assign p_ctrl[0] = hand_ctrl_i;
   assign p_vld[1]  = done_vld_i;
   assign p_last[1] = done_last_i;
   assign p_ctrl[1] = done_ctrl_i;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      cmpl_decode #(
         .CODE_W (CODE_W),
         .CTRL_W (CTRL_W),
         .POINT  ((p == 0) ? PT_HANDOFF : PT_DATA_DONE)
      ) u_dec (
         .clk       (clk),
         .rst_n     (rst_n),
         .vld_i     (p_vld[p]),
         .last_i    (p_last[p]),
         .ctrl_i    (p_ctrl[p]),
         .int_set_o (p_int[p]),
         .chn_set_o (p_chn[p])
      );
   end

   // R11
   assign pend_set  = p_int[0] | p_int[1];
   assign chain_set = p_chn[0] | p_chn[1];

   cmpl_bitreg #(.W(NUM), .SET_WINS(1'b1)) u_pend (
      .clk (clk), .rst_n (rst_n), .set_i (pend_set), .clr_i (pend_clr_i), .q_o (pend_o)
   );

   cmpl_bitreg #(.W(NUM), .SET_WINS(1'b1)) u_chain (
      .clk (clk), .rst_n (rst_n), .set_i (chain_set), .clr_i (chain_clr_i), .q_o (chain_o)
   );

   cmpl_bitreg #(.W(NUM), .SET_WINS(1'b1)) u_ien (
      .clk (clk), .rst_n (rst_n), .set_i (ien_set_i), .clr_i (ien_clr_i), .q_o (ien_o)
   );

   cmpl_irq_reduce #(.W(NUM), .LEAF(LEAF)) u_irq (
      .pend_i (pend_o), .ien_i (ien_o), .irq_o (irq_o)
   );

   // R10
   irq_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_o == '0) |-> !irq_o);
   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(pend_set | ien_set_i) != '0));
   // R6
   report_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_set != '0) |=> ((pend_o & $past(pend_set)) != '0));
endmodule

// File: tb/cmpl_event_router_bench.sv
`timescale 1ns/1ps
module cmpl_event_router_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hand_vld_i = 1'b0, hand_last_i = 1'b0;
   logic [31:0] hand_ctrl_i = '0;
   logic        done_vld_i = 1'b0, done_last_i = 1'b0;
   logic [31:0] done_ctrl_i = '0;
   logic [63:0] pend_clr_i = '0, chain_clr_i = '0, ien_set_i = '0, ien_clr_i = '0;
   logic [63:0] pend_o, chain_o, ien_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cmpl_event_router u_cmpl_event_router (
      .clk (clk), .rst_n (rst_n),
      .hand_vld_i (hand_vld_i), .hand_last_i (hand_last_i), .hand_ctrl_i (hand_ctrl_i),
      .done_vld_i (done_vld_i), .done_last_i (done_last_i), .done_ctrl_i (done_ctrl_i),
      .pend_clr_i (pend_clr_i), .chain_clr_i (chain_clr_i),
      .ien_set_i (ien_set_i), .ien_clr_i (ien_clr_i),
      .pend_o (pend_o), .chain_o (chain_o), .ien_o (ien_o), .irq_o (irq_o)
   );

   // enable nibble: [0] final int (bit 20), [1] mid int (21), [2] final chain (22), [3] mid chain (23)
   function automatic logic [31:0] mk(input logic m, input logic [3:0] en, input logic [5:0] c);
      return (32'(m) << 11) | (32'(c) << 12) | (32'(en) << 20);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      hand_vld_i = 0; hand_last_i = 0; hand_ctrl_i = '0;
      done_vld_i = 0; done_last_i = 0; done_ctrl_i = '0;
      pend_clr_i = '0; chain_clr_i = '0; ien_set_i = '0; ien_clr_i = '0;
   endtask

   // {port(1=done,0=handoff), mode, last, en[3:0], code[5:0], exp_pend, exp_chain}
   localparam logic [14:0] VEC [12] = '{
      {1'b1, 1'b0, 1'b1, 4'b0001, 6'd5,  1'b1, 1'b0},  // R2 final int on final
      {1'b1, 1'b0, 1'b0, 4'b0001, 6'd7,  1'b0, 1'b0},  // R2 final int ignores mid
      {1'b1, 1'b0, 1'b0, 4'b0010, 6'd63, 1'b1, 1'b0},  // R3 mid int on mid
      {1'b1, 1'b0, 1'b1, 4'b0010, 6'd9,  1'b0, 1'b0},  // R3 mid int ignores final
      {1'b1, 1'b0, 1'b1, 4'b0100, 6'd0,  1'b0, 1'b1},  // R4 final chain
      {1'b1, 1'b0, 1'b0, 4'b1000, 6'd33, 1'b0, 1'b1},  // R4 mid chain
      {1'b1, 1'b0, 1'b1, 4'b1000, 6'd34, 1'b0, 1'b0},  // R4 mid chain ignores final
      {1'b0, 1'b1, 1'b1, 4'b0101, 6'd40, 1'b1, 1'b1},  // R5 early on handoff
      {1'b0, 1'b0, 1'b1, 4'b0101, 6'd41, 1'b0, 1'b0},  // R5 normal on handoff ignored
      {1'b1, 1'b1, 1'b1, 4'b0101, 6'd42, 1'b0, 1'b0},  // R5 early on done ignored
      {1'b1, 1'b0, 1'b0, 4'b1111, 6'd17, 1'b1, 1'b1},  // R3 R4 all enables, mid
      {1'b0, 1'b1, 1'b0, 4'b0011, 6'd1,  1'b1, 1'b0}   // R5 R3 early mid
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      idle();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pend", pend_o, '0);
      chk("R1 chain", chain_o, '0);
      chk("R1 ien", ien_o, '0);
      chk("R1 irq", 64'(irq_o), '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 12; i++) begin
         logic [14:0] v;
         logic [63:0] ep, ec;
         v  = VEC[i];
         ep = v[1] ? (64'd1 << v[7:2]) : '0;
         ec = v[0] ? (64'd1 << v[7:2]) : '0;
         if (v[14]) begin
            done_vld_i = 1; done_last_i = v[12]; done_ctrl_i = mk(v[13], v[11:8], v[7:2]);
         end else begin
            hand_vld_i = 1; hand_last_i = v[12]; hand_ctrl_i = mk(v[13], v[11:8], v[7:2]);
         end
         #1;
         if (i == 0) chk("R6 not yet visible", pend_o, '0);
         @(negedge clk);
         idle();
         chk($sformatf("R2-table pend vec%0d", i), pend_o, ep);
         chk($sformatf("R4-table chain vec%0d", i), chain_o, ec);
         chk("R10 irq masked", 64'(irq_o), '0);
         pend_clr_i = '1; chain_clr_i = '1;
         @(negedge clk);
         idle();
         chk("R7 clear all pend", pend_o, '0);
         chk("R7 clear all chain", chain_o, '0);
      end

      // R7 selective clear
      done_vld_i = 1; done_last_i = 1; done_ctrl_i = mk(0, 4'b0001, 6'd3);
      @(negedge clk);
      done_ctrl_i = mk(0, 4'b0001, 6'd4);
      @(negedge clk);
      idle();
      chk("R7 two bits set", pend_o, 64'h18);
      pend_clr_i = 64'h8;
      @(negedge clk);
      idle();
      chk("R7 selective clear", pend_o, 64'h10);

      // R8 set beats clear on pending and chain
      done_vld_i = 1; done_last_i = 1; done_ctrl_i = mk(0, 4'b0101, 6'd10);
      pend_clr_i = 64'h400; chain_clr_i = 64'h400;
      @(negedge clk);
      idle();
      chk("R8 pend set wins", pend_o, 64'h410);
      chk("R8 chain set wins", chain_o, 64'h400);

      // R9 enable set / clear
      ien_set_i = 64'h10;
      #1;
      chk("R10 irq before enable", 64'(irq_o), '0);
      @(negedge clk);
      idle();
      chk("R9 ien set", ien_o, 64'h10);
      chk("R10 irq raised", 64'(irq_o), 64'd1);
      ien_set_i = 64'h40; ien_clr_i = 64'h40;
      @(negedge clk);
      idle();
      chk("R9 ien set wins", ien_o, 64'h50);
      ien_clr_i = 64'h50;
      @(negedge clk);
      idle();
      chk("R9 ien cleared", ien_o, '0);
      chk("R10 irq low with pend but no enable", 64'(irq_o), '0);
      chk("R10 pend kept", pend_o, 64'h410);
      ien_set_i = 64'h100000;
      @(negedge clk);
      idle();
      chk("R10 enable without pend", 64'(irq_o), '0);
      pend_clr_i = '1; chain_clr_i = '1; ien_clr_i = '1;
      @(negedge clk);
      idle();

      // R11 both ports in one cycle
      hand_vld_i = 1; hand_last_i = 1; hand_ctrl_i = mk(1, 4'b0001, 6'd50);
      done_vld_i = 1; done_last_i = 0; done_ctrl_i = mk(0, 4'b1000, 6'd51);
      @(negedge clk);
      idle();
      chk("R11 both pend", pend_o, 64'd1 << 50);
      chk("R11 both chain", chain_o, 64'd1 << 51);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule